// File: doc/BRIEF.md
# Floating-Point Dual Add-Subtract Unit

This unit performs addition and subtraction on a pair of 44-bit floating-point words. Each word has a sign bit (bit 43), an 11-bit exponent (bits 42:32) and a 32-bit fraction (bits 31:0) with an implied leading one. An exponent of zero marks the value zero. One opcode gives the sum, another gives the difference, and a third gives both from the same pair in one pass. That third case matches the butterfly step of a transform. The same unit also handles 32-bit integer add, subtract, left shift and right shift.

Each operation passes through one input register and one output register. A result appears two cycles after its operands are accepted, and the unit can take a new operation every cycle. The valid signal travels with the data and there is no back-pressure. Floating-point results are aligned, normalized and rounded to nearest-even. Infinities, NaNs, denormals, exponent overflow and exception flags are not handled.

Top module: `fp_dual_addsub`

## Requirements
- R1: `out_valid` goes high exactly two clock cycles after each cycle in which `in_valid` is high. The unit accepts one operation every cycle, and results leave in the order their operands arrived.
- R2: Opcode 0 sets `out_a` to the sum A+B, rounded, and sets `out_b` to zero.
- R3: Opcode 1 sets `out_a` to the difference A−B, rounded, and sets `out_b` to zero.
- R4: Opcodes 2 and 3 set `out_a` to A+B and `out_b` to A−B, both computed from the same operand pair.
- R5: A floating-point result is rounded to nearest. On an exact tie it rounds to the value whose fraction LSB is 0. A carry out of rounding raises the exponent by one.
- R6: Any operand with exponent 0 counts as zero, whatever its fraction bits hold. An exactly zero result is encoded as all 44 bits cleared, which is a positive sign.
- R7: When the exponents differ by more than the significand width, the smaller operand still affects rounding through a sticky bit.
- R8: Opcode 4 gives the integer sum and opcode 5 gives the integer difference of bits 31:0, modulo 2^32. These appear in `out_a[31:0]`. `out_a[43:32]` and `out_b` are zero.
- R9: Opcode 6 shifts A[31:0] left by B[4:0] and fills with zeros.
- R10: Opcode 7 shifts A[31:0] right by B[4:0]. The shift is arithmetic when `in_signed` is 1 and logical when it is 0. `in_signed` has no effect on the other opcodes.
- R11: While `rst_n` is low, `out_valid` is 0 and both results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are present this cycle |
| in_op | input | 3 | Opcode: 0 add, 1 sub, 2/3 add and sub, 4 int add, 5 int sub, 6 shift left, 7 shift right |
| in_signed | input | 1 | Integer operands are signed (selects the right-shift kind) |
| in_a | input | 44 | Operand A |
| in_b | input | 44 | Operand B (shift amount in bits 4:0) |
| out_valid | output | 1 | Results are present this cycle |
| out_a | output | 44 | Primary result |
| out_b | output | 44 | Difference for add-and-sub, else zero |

## Verification
The properties assume that `in_op` and the operands are known whenever `in_valid` is high. They also assume that exponents stay far enough from both ends of the range that neither normalization nor a rounding carry can push the result exponent out of range. The stimulus keeps every floating-point exponent between 800 and 1300, so no result can overflow or underflow. The largest exponent gap used (about 200) is still far wider than the significand, which exercises the sticky path. The reference model adds the values exactly in a 256-bit integer and rounds only once at the end. This makes it independent of the hardware's guard/round/sticky shortcut.

// File: rtl/fp_dual_addsub.sv
module fp_dual_addsub #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [2:0]                 in_op,
  input  logic                       in_signed,
  input  logic [EXP_W+MAN_W:0]       in_a,
  input  logic [EXP_W+MAN_W:0]       in_b,
  output logic                       out_valid,
  output logic [EXP_W+MAN_W:0]       out_a,
  output logic [EXP_W+MAN_W:0]       out_b
);
  localparam int W   = 1 + EXP_W + MAN_W;
  localparam int SIG = MAN_W + 1;
  localparam int RW  = SIG + 4;
  localparam int TW  = 2 * SIG + 2;
  localparam int LZW = $clog2(RW + 1);
  localparam int SHW = $clog2(MAN_W);

  logic         vld_q, sgn_q;
  logic [2:0]   op_q;
  logic [W-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0; sgn_q <= 1'b0; op_q <= '0; a_q <= '0; b_q <= '0;
    end else begin
      vld_q <= in_valid; sgn_q <= in_signed; op_q <= in_op; a_q <= in_a; b_q <= in_b;
    end
  end

  function automatic logic [LZW-1:0] lzc(input logic [RW-1:0] v);
    lzc = LZW'(RW);
    for (int i = 0; i < RW; i++)
      if (v[i]) lzc = LZW'(RW - 1 - i);
  endfunction

  wire [EXP_W-1:0] ea = a_q[W-2:MAN_W];
  wire [EXP_W-1:0] eb = b_q[W-2:MAN_W];
  wire [SIG-1:0]   siga = (ea == '0) ? '0 : {1'b1, a_q[MAN_W-1:0]};
  wire [SIG-1:0]   sigb = (eb == '0) ? '0 : {1'b1, b_q[MAN_W-1:0]};
  wire             a_big = a_q[W-2:0] >= b_q[W-2:0];

  wire [EXP_W-1:0] e_big   = a_big ? ea : eb;
  wire [EXP_W-1:0] dexp    = a_big ? ea - eb : eb - ea;
  wire [SIG-1:0]   sig_big = a_big ? siga : sigb;
  wire [SIG-1:0]   sig_sml = a_big ? sigb : siga;

  wire [TW-1:0]    tsh = {sig_sml, {(SIG+2){1'b0}}} >> dexp;
  wire             stk = (32'(dexp) >= TW) ? |sig_sml : |tsh[SIG-1:0];
  wire [RW-2:0]    al_big = {sig_big, 3'b000};
  wire [RW-2:0]    al_sml = {tsh[TW-1:SIG], stk};

  logic [W-1:0] fres [2];

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic            eff_sub, sgn_r, inc;
    logic [RW-1:0]   r, n;
    logic [LZW-1:0]  lz;
    logic [SIG:0]    m;
    logic [EXP_W:0]  ex;
    always_comb begin
      eff_sub = a_q[W-1] ^ b_q[W-1] ^ (p == 1);
      sgn_r   = a_big ? a_q[W-1] : (b_q[W-1] ^ (p == 1));
      r       = eff_sub ? {1'b0, al_big} - {1'b0, al_sml} : {1'b0, al_big} + {1'b0, al_sml};
      lz      = lzc(r);
      n       = r << lz;
      inc     = n[RW-SIG-1] & ((|n[RW-SIG-2:0]) | n[RW-SIG]);
      m       = {1'b0, n[RW-1:RW-SIG]} + (SIG+1)'(inc);
      ex      = (EXP_W+1)'(e_big) + 1'b1 - (EXP_W+1)'(lz) + (EXP_W+1)'(m[SIG]);
      fres[p] = (r == '0) ? '0 : {sgn_r, ex[EXP_W-1:0], m[SIG] ? {MAN_W{1'b0}} : m[MAN_W-1:0]};
    end
  end

  wire [MAN_W-1:0] ia  = a_q[MAN_W-1:0];
  wire [MAN_W-1:0] ib  = b_q[MAN_W-1:0];
  wire [SHW-1:0]   amt = ib[SHW-1:0];
  logic [MAN_W-1:0] ires;

  always_comb begin
    case (op_q[1:0])
      2'd0:    ires = ia + ib;
      2'd1:    ires = ia - ib;
      2'd2:    ires = ia << amt;
      default: ires = sgn_q ? MAN_W'($signed(ia) >>> amt) : ia >> amt;
    endcase
  end

  logic [W-1:0] nxt_a, nxt_b;
  always_comb begin
    if (op_q[2]) begin
      nxt_a = {{(W-MAN_W){1'b0}}, ires};
      nxt_b = '0;
    end else if (op_q[1]) begin
      nxt_a = fres[0];
      nxt_b = fres[1];
    end else begin
      nxt_a = op_q[0] ? fres[1] : fres[0];
      nxt_b = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_a <= '0; out_b <= '0;
    end else begin
      out_valid <= vld_q; out_a <= nxt_a; out_b <= nxt_b;
    end
  end
endmodule

// File: rtl/fp_dual_addsub_chk.sv
module fp_dual_addsub_chk #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [2:0]           in_op,
  input logic [EXP_W+MAN_W:0] in_a,
  input logic [EXP_W+MAN_W:0] in_b,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] out_a,
  input logic [EXP_W+MAN_W:0] out_b
);
  localparam int W = 1 + EXP_W + MAN_W;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_int_second_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[2]) |-> ##2 (out_b == '0 && out_a[W-1:MAN_W] == '0));
  assert_sum_diff_agree_on_zero_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[2:1] == 2'b01 && in_b[W-2:MAN_W] == '0) |-> ##2 (out_a == out_b));
  assert_zero_is_positive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op[2]) |-> ##2 (out_a[W-2:MAN_W] != '0 || out_a == '0));
  assert_shift_zero_amount_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd6 && in_b[4:0] == 5'd0) |-> ##2 (out_a[MAN_W-1:0] == $past(in_a[MAN_W-1:0], 2)));
  assert_reset_clears_R11: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_a == '0 && out_b == '0));
endmodule

bind fp_dual_addsub fp_dual_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
);

// File: tb/fp_dual_addsub_bench.sv
module fp_dual_addsub_bench;
  logic clk = 0, rst_n = 0, in_valid = 0, in_signed = 0;
  logic [2:0] in_op = '0;
  logic [43:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic [43:0] out_a, out_b;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [43:0] q_a[$], q_b[$];
  string q_tag[$];

  always #5 clk = ~clk;

  fp_dual_addsub u_fp_dual_addsub (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_signed(in_signed), .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_a(out_a), .out_b(out_b));

  function automatic logic [43:0] fpv(bit s, int e, logic [31:0] f);
    return {s, e[10:0], f};
  endfunction

  function automatic logic [43:0] fp_ref(logic [43:0] a, logic [43:0] b, bit negb);
    bit sa = a[43], sb = b[43] ^ negb, s, guard, sticky;
    int ea = int'(a[42:32]), eb = int'(b[42:32]), emin, p, er, sh;
    logic [255:0] va, vb, mag;
    logic [32:0] sig33;
    logic [33:0] sig34;
    if (ea == 0 && eb == 0) return '0;
    if (ea == 0) return {sb, b[42:0]};
    if (eb == 0) return a;
    emin = (ea < eb) ? ea : eb;
    va = {223'b0, 1'b1, a[31:0]} << (ea - emin);
    vb = {223'b0, 1'b1, b[31:0]} << (eb - emin);
    if (sa == sb) begin mag = va + vb; s = sa; end
    else if (va > vb) begin mag = va - vb; s = sa; end
    else if (vb > va) begin mag = vb - va; s = sb; end
    else return '0;
    p = 0;
    for (int i = 0; i < 256; i++) if (mag[i]) p = i;
    er = emin + p - 32;
    if (p <= 32) begin
      mag = mag << (32 - p);
      return {s, er[10:0], mag[31:0]};
    end
    sh = p - 32;
    sig33 = 33'(mag >> sh);
    guard = mag[sh-1];
    sticky = 0;
    for (int i = 0; i < sh - 1; i++) sticky |= mag[i];
    sig34 = {1'b0, sig33} + 34'(guard & (sticky | sig33[0]));
    if (sig34[33]) begin er++; return {s, er[10:0], 32'b0}; end
    return {s, er[10:0], sig34[31:0]};
  endfunction

  task automatic send(logic [2:0] op, bit sgn, logic [43:0] a, logic [43:0] b, string tag);
    logic [43:0] ra, rb;
    logic [31:0] x = a[31:0], y = b[31:0];
    rb = '0;
    case (op)
      3'd0: ra = fp_ref(a, b, 0);
      3'd1: ra = fp_ref(a, b, 1);
      3'd2, 3'd3: begin ra = fp_ref(a, b, 0); rb = fp_ref(a, b, 1); end
      3'd4: ra = {12'b0, x + y};
      3'd5: ra = {12'b0, x - y};
      3'd6: ra = {12'b0, x << y[4:0]};
      default: ra = {12'b0, sgn ? 32'($signed(x) >>> y[4:0]) : x >> y[4:0]};
    endcase
    in_valid = 1; in_op = op; in_signed = sgn; in_a = a; in_b = b;
    q_a.push_back(ra); q_b.push_back(rb); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 0; in_a = $urandom; in_b = $urandom;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [43:0] rnd_fp();
    return fpv($urandom_range(0, 1), 900 + $urandom_range(0, 200), $urandom);
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q_a.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected out_valid, actual a=%h b=%h expected none", out_a, out_b);
      end else begin
        logic [43:0] ea, eb;
        string t;
        ea = q_a.pop_front(); eb = q_b.pop_front(); t = q_tag.pop_front();
        if (out_a !== ea || out_b !== eb) begin
          errors++;
          $display("FAIL %s: actual a=%h b=%h expected a=%h b=%h", t, out_a, out_b, ea, eb);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_a !== '0 || out_b !== '0) begin
      errors++;
      $display("FAIL R11: actual v=%b a=%h b=%h expected 0/0/0", out_valid, out_a, out_b);
    end
    rst_n = 1;
    // R2, R3 basic
    send(0, 0, fpv(0, 1023, 0), fpv(0, 1023, 0), "R2");
    send(1, 0, fpv(0, 1024, 32'h8000_0000), fpv(0, 1023, 0), "R3");
    send(1, 0, fpv(0, 1023, 0), fpv(0, 1024, 0), "R3");
    send(0, 0, fpv(1, 1000, 32'h1234_5678), fpv(0, 1001, 32'h0), "R2");
    // R4 both results, same pair and opposite-sign
    send(2, 0, fpv(0, 1030, 32'hABCD_0001), fpv(1, 1028, 32'h0F0F_0F0F), "R4");
    send(3, 0, fpv(1, 1010, 32'h5555_5555), fpv(1, 1010, 32'h5555_5554), "R4");
    // R6 equal operands cancel to +0; zero operand with junk fraction
    send(2, 0, fpv(1, 1100, 32'h0000_00FF), fpv(1, 1100, 32'h0000_00FF), "R6");
    send(0, 0, fpv(1, 0, 32'hDEAD_BEEF), fpv(1, 1050, 32'h1), "R6");
    send(1, 0, fpv(0, 1050, 32'h7), fpv(1, 0, 32'hFFFF_FFFF), "R6");
    send(1, 0, fpv(0, 0, 32'h1), fpv(1, 0, 32'h2), "R6");
    // R5 ties and carry
    send(0, 0, fpv(0, 1000, 0), fpv(0, 967, 0), "R5");
    send(0, 0, fpv(0, 1000, 1), fpv(0, 967, 0), "R5");
    send(0, 0, fpv(0, 1000, 0), fpv(0, 967, 1), "R5");
    send(0, 0, fpv(0, 1000, 32'hFFFF_FFFF), fpv(0, 967, 0), "R5");
    // R7 huge exponent gap: sticky
    send(1, 0, fpv(0, 1100, 0), fpv(0, 900, 32'h1), "R7");
    send(0, 0, fpv(0, 1100, 1), fpv(0, 1040, 0), "R7");
    send(1, 0, fpv(0, 1100, 0), fpv(0, 1066, 0), "R7");
    // R8 integer add/sub, signedness ignored
    send(4, 0, {12'hFFF, 32'hFFFF_FFFF}, 44'h2, "R8");
    send(5, 1, 44'h3, 44'h5, "R8");
    send(5, 0, 44'h3, 44'h5, "R8");
    // R9 left shift
    send(6, 0, 44'h8000_0001, 44'h1, "R9");
    send(6, 1, 44'h1234_5678, 44'h0, "R9");
    send(6, 0, 44'h1, {39'h7F, 5'd31}, "R9");
    // R10 right shift
    send(7, 1, 44'h8000_0000, 44'd31, "R10");
    send(7, 0, 44'h8000_0000, 44'd31, "R10");
    send(7, 1, 44'h7000_0000, 44'd4, "R10");
    send(7, 1, 44'hF000_0010, 44'd0, "R10");
    idle(3);
    // R1 back-to-back random stream with gaps
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 7);
      if (op < 4) send(3'(op), $urandom_range(0, 1), rnd_fp(), rnd_fp(), "R1");
      else send(3'(op), $urandom_range(0, 1), {12'b0, 32'($urandom)}, {12'b0, 32'($urandom)}, "R1");
      if (i % 37 == 0) idle($urandom_range(1, 3));
    end
    idle(5);
    checks++;
    if (q_a.size() != 0) begin
      errors++;
      $display("FAIL R1: actual %0d results missing expected 0", q_a.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1: watchdog expired, actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule